// File: doc/BRIEF.md
# USB Device Endpoint Buffer Controller

This block keeps the bookkeeping for the packet buffers of a small set of USB device endpoints. It sits between a processor and the USB serial engine. The processor first writes an index register that names an endpoint, a direction and whether the control SETUP buffer is meant. After that, byte writes, byte reads, max-packet-size writes and one-byte function commands all act on that buffer. The serial engine presents its own endpoint selection. For that buffer it sees whether a packet is ready to send, or whether there is room to receive one. It then reports a completed send or a completed receive.

Each buffer holds a byte count and a valid flag per slot. An IN buffer becomes valid for sending when the processor has written max-packet-size bytes, or when the processor issues a validate command. An OUT buffer is freed once the processor has read its last byte, and an IN buffer is freed once the engine reports it sent. Data endpoints can run with two slots in ping-pong order. Forced clearing and a sticky stall flag handle abnormal cases. The packet memory itself, token decoding and DMA live elsewhere.

Top module: `usb_epbuf_ctrl`

## Requirements
- R1: The index register selects a buffer. For endpoint 0, SETUP-select 1 picks the SETUP buffer whatever the direction is. Endpoint 0 with SETUP-select 0 picks control OUT when the direction is 0 and control IN when it is 1. For a nonzero endpoint the SETUP-select bit is ignored, and direction 0 picks data OUT while direction 1 picks data IN. The USB-side selection decodes the same way.
- R2: After `rst_n` low, or after a one-cycle `bus_rst`, every buffer is empty and unstalled and `fn_rdata` reads 0. An empty buffer gives `cpu_cnt`=0, `cpu_ready`=1 for IN and 0 for OUT, and `usb_ready`=0 for IN and 1 for OUT. Max packet size returns to `MPS_DEF` only on `rst_n`; `bus_rst` keeps it.
- R3: A `usb_rx_done` into a free OUT slot loads `usb_rx_len` bytes. Each `cpu_rd_stb` lowers `cpu_cnt` by one. The read of the last byte, or the read of a zero-length packet, frees that slot.
- R4: Each `cpu_wr_stb` to a non-valid IN slot raises its count by one. The write that brings the count to the max packet size makes the slot valid, and then `usb_ready`=1 and `usb_len` equals the max packet size.
- R5: A `usb_tx_done` on a valid, unstalled IN buffer frees the slot that was offered.
- R6: A function write with bit 3 set makes a non-valid IN slot valid at its current count, zero included. On an OUT buffer it has no effect.
- R7: Bit 0 of every function write sets the stall flag of the indexed buffer, and `fn_rdata` bit 0 reads it back. While the flag is set, `usb_stall`=1 and `usb_ready`=0, and both `usb_tx_done` and `usb_rx_done` are ignored.
- R8: A function write with bit 4 set flushes one slot. On an IN buffer it flushes the oldest valid slot, or if none is valid it empties the count of the slot being filled. On an OUT buffer it flushes the oldest valid slot.
- R9: When `DBL_DATA`=1, each data endpoint buffer has two slots used in ping-pong order. The processor can fill or read one slot while the other waits on the USB side, and emptying both slots by force takes two clear commands. Control and SETUP buffers always have one slot.
- R10: Function bits 7 to 5 are ignored, and `fn_rdata` bits 7 to 1 always read 0. Bit 2 yields a one-cycle `dsen_pls` and bit 1 a one-cycle `status_pls`, both in the cycle after the write, and neither changes any buffer.
- R11: `mps_we` writes `mps_wdata` as the max packet size of the indexed buffer. The value must be 1 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_rst | input | 1 | One-cycle USB bus reset |
| idx_we | input | 1 | Write index register |
| idx_ep | input | EP_W | Endpoint number |
| idx_dir | input | 1 | Direction, 1 = IN |
| idx_setup | input | 1 | SETUP buffer select |
| fn_we | input | 1 | Write function register |
| fn_wdata | input | 8 | Function command byte |
| fn_rdata | output | 8 | Function readback (stall in bit 0) |
| mps_we | input | 1 | Write max packet size of indexed buffer |
| mps_wdata | input | EPB_CNT_W | Max packet size value |
| cpu_wr_stb | input | 1 | Processor wrote one byte to indexed IN buffer |
| cpu_rd_stb | input | 1 | Processor read one byte from indexed OUT buffer |
| cpu_cnt | output | EPB_CNT_W | Byte count of processor-side slot |
| cpu_ready | output | 1 | IN: slot writable; OUT: slot holds data |
| dsen_pls | output | 1 | Data stage enable pulse |
| status_pls | output | 1 | Status stage pulse |
| usb_ep | input | EP_W | Engine endpoint select |
| usb_dir | input | 1 | Engine direction select |
| usb_setup | input | 1 | Engine SETUP select |
| usb_rx_done | input | 1 | Packet received into selected buffer |
| usb_rx_len | input | EPB_CNT_W | Received packet length |
| usb_tx_done | input | 1 | Offered packet sent |
| usb_ready | output | 1 | IN: packet valid to send; OUT: slot free |
| usb_len | output | EPB_CNT_W | Byte count of USB-side slot |
| usb_stall | output | 1 | Selected buffer is stalled |

## Verification
The in-module assertions watch the buffer transitions on every cycle. A fill that reaches the max packet size leaves that slot valid. A send leaves the offered slot free, and the read of the last byte frees its slot. A stalled selection never shows as ready. The bench scenarios show the rest: the buffer decode with its SETUP priority, the ping-pong order across two slots, clears that take one command per slot, validate being ignored on OUT buffers, and bus reset keeping the max packet size. Random max packet sizes and packet lengths probe the fill and drain arithmetic.

// File: rtl/usb_epbuf_pkg.sv
package usb_epbuf_pkg;
  localparam int EPB_CNT_W = 11;
  typedef logic [EPB_CNT_W-1:0] epb_cnt_t;

  typedef struct packed {
    logic clr;
    logic val;
    logic stall_we;
    logic stall_v;
  } epb_cmd_t;

  // true when one more byte makes the slot reach max packet size
  function automatic logic epb_full_after_write(epb_cnt_t cnt, epb_cnt_t mps);
    return (cnt + 1'b1) == mps;
  endfunction

  // buffer number: endpoint*2+direction, SETUP buffer last
  function automatic int unsigned epb_buf_id(int unsigned ep, logic dir,
                                             logic setup, int unsigned nep);
    if (ep == 0 && setup) return 2 * nep;
    return 2 * ep + (dir ? 1 : 0);
  endfunction
endpackage

// File: rtl/epbuf_cmd.sv
module epbuf_cmd
  import usb_epbuf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_rst,
  input  logic       fn_we,
  input  logic [7:0] fn_wdata,
  output epb_cmd_t   cmd,
  output logic       dsen_pls,
  output logic       status_pls
);
  // bits 7..5 are not decoded at all
  logic [4:0] fn_low;
  assign fn_low = fn_wdata[4:0];

  assign cmd.clr      = fn_we & fn_low[4];
  assign cmd.val      = fn_we & fn_low[3];
  assign cmd.stall_we = fn_we;
  assign cmd.stall_v  = fn_low[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dsen_pls   <= 1'b0;
      status_pls <= 1'b0;
    end else if (bus_rst) begin
      dsen_pls   <= 1'b0;
      status_pls <= 1'b0;
    end else begin
      dsen_pls   <= fn_we & fn_low[2];
      status_pls <= fn_we & fn_low[1];
    end
  end

  logic unused_hi;
  assign unused_hi = ^fn_wdata[7:5];
endmodule

// File: rtl/epbuf_slot.sv
module epbuf_slot
  import usb_epbuf_pkg::*;
#(
  parameter bit IS_IN   = 1'b0,
  parameter bit DBL     = 1'b0,
  parameter int MPS_DEF = 64
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     bus_rst,
  input  logic     cpu_wr,
  input  logic     cpu_rd,
  input  epb_cmd_t cmd,
  input  logic     mps_we,
  input  epb_cnt_t mps_wdata,
  input  logic     rx_done,
  input  epb_cnt_t rx_len,
  input  logic     tx_done,
  output epb_cnt_t cpu_cnt,
  output logic     cpu_ready,
  output logic     usb_ready,
  output epb_cnt_t usb_len,
  output logic     stall_o
);
  epb_cnt_t cnt   [2];
  epb_cnt_t n_cnt [2];
  logic [1:0] vld, n_vld;
  logic cp, up, n_cp, n_up;
  logic stall_q;
  epb_cnt_t mps_q;

  function automatic logic adv(logic p);
    return DBL ? ~p : 1'b0;
  endfunction

  // named events for the checks
  logic ev_fill, ev_tx, ev_drain;
  assign ev_fill  = IS_IN && cpu_wr && !vld[cp] && epb_full_after_write(cnt[cp], mps_q);
  assign ev_tx    = IS_IN && tx_done && vld[up] && !stall_q;
  assign ev_drain = !IS_IN && cpu_rd && vld[cp] && (cnt[cp] <= epb_cnt_t'(1));

  always_comb begin
    n_cnt = cnt;
    n_vld = vld;
    n_cp  = cp;
    n_up  = up;
    if (IS_IN) begin
      if (ev_tx) begin
        n_vld[up] = 1'b0;
        n_cnt[up] = '0;
        n_up      = adv(up);
      end
      if (cpu_wr && !vld[cp]) begin
        n_cnt[cp] = cnt[cp] + 1'b1;
        if (ev_fill) begin
          n_vld[cp] = 1'b1;
          n_cp      = adv(cp);
        end
      end else if (cmd.val && !vld[cp]) begin
        n_vld[cp] = 1'b1;
        n_cp      = adv(cp);
      end
      if (cmd.clr) begin
        if (vld[up]) begin
          n_vld[up] = 1'b0;
          n_cnt[up] = '0;
          n_up      = adv(up);
        end else begin
          n_cnt[cp] = '0;
        end
      end
    end else begin
      if (rx_done && !vld[up] && !stall_q) begin
        n_vld[up] = 1'b1;
        n_cnt[up] = rx_len;
        n_up      = adv(up);
      end
      if (cpu_rd && vld[cp]) begin
        n_cnt[cp] = cnt[cp] - 1'b1;
        if (ev_drain) begin
          n_vld[cp] = 1'b0;
          n_cnt[cp] = '0;
          n_cp      = adv(cp);
        end
      end
      if (cmd.clr && vld[cp]) begin
        n_vld[cp] = 1'b0;
        n_cnt[cp] = '0;
        n_cp      = adv(cp);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt[0]  <= '0;
      cnt[1]  <= '0;
      vld     <= '0;
      cp      <= 1'b0;
      up      <= 1'b0;
      stall_q <= 1'b0;
      mps_q   <= epb_cnt_t'(MPS_DEF);
    end else begin
      if (bus_rst) begin
        cnt[0]  <= '0;
        cnt[1]  <= '0;
        vld     <= '0;
        cp      <= 1'b0;
        up      <= 1'b0;
        stall_q <= 1'b0;
      end else begin
        cnt     <= n_cnt;
        vld     <= n_vld;
        cp      <= n_cp;
        up      <= n_up;
        if (cmd.stall_we) stall_q <= cmd.stall_v;
      end
      if (mps_we) mps_q <= mps_wdata;
    end
  end

  assign cpu_cnt   = cnt[cp];
  assign cpu_ready = IS_IN ? !vld[cp] : vld[cp];
  assign usb_ready = !stall_q && (IS_IN ? vld[up] : !vld[up]);
  assign usb_len   = cnt[up];
  assign stall_o   = stall_q;

  // R4: a fill to max packet size leaves the slot valid
  a_r4_fill_validates: assert property (@(posedge clk) disable iff (!rst_n || bus_rst)
    ev_fill |=> vld[$past(cp)]);

  // R5: a completed send frees the offered slot
  a_r5_tx_frees: assert property (@(posedge clk) disable iff (!rst_n || bus_rst)
    ev_tx |=> !vld[$past(up)]);

  // R3: reading the last byte frees the slot
  a_r3_drain_frees: assert property (@(posedge clk) disable iff (!rst_n || bus_rst)
    ev_drain |=> !vld[$past(cp)]);
endmodule

// File: rtl/usb_epbuf_ctrl.sv
module usb_epbuf_ctrl
  import usb_epbuf_pkg::*;
#(
  parameter int NUM_EP   = 4,
  parameter bit DBL_DATA = 1'b1,
  parameter int MPS_DEF  = 64,
  localparam int EP_W    = $clog2(NUM_EP),
  localparam int NBUF    = 2 * NUM_EP + 1,
  localparam int BID_W   = $clog2(NBUF),
  localparam int NSEL    = 1 << BID_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_rst,
  input  logic                 idx_we,
  input  logic [EP_W-1:0]      idx_ep,
  input  logic                 idx_dir,
  input  logic                 idx_setup,
  input  logic                 fn_we,
  input  logic [7:0]           fn_wdata,
  output logic [7:0]           fn_rdata,
  input  logic                 mps_we,
  input  logic [EPB_CNT_W-1:0] mps_wdata,
  input  logic                 cpu_wr_stb,
  input  logic                 cpu_rd_stb,
  output logic [EPB_CNT_W-1:0] cpu_cnt,
  output logic                 cpu_ready,
  output logic                 dsen_pls,
  output logic                 status_pls,
  input  logic [EP_W-1:0]      usb_ep,
  input  logic                 usb_dir,
  input  logic                 usb_setup,
  input  logic                 usb_rx_done,
  input  logic [EPB_CNT_W-1:0] usb_rx_len,
  input  logic                 usb_tx_done,
  output logic                 usb_ready,
  output logic [EPB_CNT_W-1:0] usb_len,
  output logic                 usb_stall
);
  logic [EP_W-1:0] ix_ep_q;
  logic            ix_dir_q, ix_setup_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ix_ep_q    <= '0;
      ix_dir_q   <= 1'b0;
      ix_setup_q <= 1'b0;
    end else if (idx_we) begin
      ix_ep_q    <= idx_ep;
      ix_dir_q   <= idx_dir;
      ix_setup_q <= idx_setup;
    end
  end

  logic [BID_W-1:0] cpu_bid, usb_bid;
  assign cpu_bid = BID_W'(epb_buf_id(32'(ix_ep_q), ix_dir_q, ix_setup_q, NUM_EP));
  assign usb_bid = BID_W'(epb_buf_id(32'(usb_ep), usb_dir, usb_setup, NUM_EP));

  epb_cmd_t cmd_s;
  epbuf_cmd u_cmd (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rst    (bus_rst),
    .fn_we      (fn_we),
    .fn_wdata   (fn_wdata),
    .cmd        (cmd_s),
    .dsen_pls   (dsen_pls),
    .status_pls (status_pls)
  );

  epb_cnt_t  ccnt_a [NSEL];
  epb_cnt_t  ulen_a [NSEL];
  logic [NSEL-1:0] crdy_a, urdy_a, stall_a;

  for (genvar b = 0; b < NSEL; b++) begin : g_buf
    if (b < NBUF) begin : g_used
      localparam bit B_IN  = (b < 2 * NUM_EP) && (b % 2 == 1);
      localparam bit B_DBL = DBL_DATA && (b >= 2) && (b < 2 * NUM_EP);
      logic cs, us;
      epb_cmd_t bc;
      assign cs = (cpu_bid == BID_W'(b));
      assign us = (usb_bid == BID_W'(b));
      assign bc = '{clr: cmd_s.clr & cs, val: cmd_s.val & cs,
                    stall_we: cmd_s.stall_we & cs, stall_v: cmd_s.stall_v};
      epbuf_slot #(.IS_IN(B_IN), .DBL(B_DBL), .MPS_DEF(MPS_DEF)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_rst   (bus_rst),
        .cpu_wr    (cpu_wr_stb & cs),
        .cpu_rd    (cpu_rd_stb & cs),
        .cmd       (bc),
        .mps_we    (mps_we & cs),
        .mps_wdata (mps_wdata),
        .rx_done   (usb_rx_done & us),
        .rx_len    (usb_rx_len),
        .tx_done   (usb_tx_done & us),
        .cpu_cnt   (ccnt_a[b]),
        .cpu_ready (crdy_a[b]),
        .usb_ready (urdy_a[b]),
        .usb_len   (ulen_a[b]),
        .stall_o   (stall_a[b])
      );
    end else begin : g_pad
      assign ccnt_a[b]  = '0;
      assign ulen_a[b]  = '0;
      assign crdy_a[b]  = 1'b0;
      assign urdy_a[b]  = 1'b0;
      assign stall_a[b] = 1'b0;
    end
  end

  assign cpu_cnt   = ccnt_a[cpu_bid];
  assign cpu_ready = crdy_a[cpu_bid];
  assign usb_len   = ulen_a[usb_bid];
  assign usb_ready = urdy_a[usb_bid];
  assign usb_stall = stall_a[usb_bid];
  assign fn_rdata  = {7'b0, stall_a[cpu_bid]};

  // R7: a stalled selection is never offered to the USB side
  a_r7_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    usb_stall |-> !usb_ready);
endmodule

// File: tb/usb_epbuf_ctrl_tb_top.sv
`timescale 1ns/1ps
module usb_epbuf_ctrl_tb_top;
  localparam int CW = 11;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, bus_rst = 1'b0;
  logic idx_we = 0, idx_dir = 0, idx_setup = 0;
  logic [1:0] idx_ep = 0;
  logic fn_we = 0;
  logic [7:0] fn_wdata = 0, fn_rdata;
  logic mps_we = 0;
  logic [CW-1:0] mps_wdata = 0;
  logic cpu_wr_stb = 0, cpu_rd_stb = 0;
  logic [CW-1:0] cpu_cnt;
  logic cpu_ready, dsen_pls, status_pls;
  logic [1:0] usb_ep = 0;
  logic usb_dir = 0, usb_setup = 0, usb_rx_done = 0, usb_tx_done = 0;
  logic [CW-1:0] usb_rx_len = 0;
  logic usb_ready, usb_stall;
  logic [CW-1:0] usb_len;

  usb_epbuf_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst),
    .idx_we(idx_we), .idx_ep(idx_ep), .idx_dir(idx_dir), .idx_setup(idx_setup),
    .fn_we(fn_we), .fn_wdata(fn_wdata), .fn_rdata(fn_rdata),
    .mps_we(mps_we), .mps_wdata(mps_wdata),
    .cpu_wr_stb(cpu_wr_stb), .cpu_rd_stb(cpu_rd_stb),
    .cpu_cnt(cpu_cnt), .cpu_ready(cpu_ready),
    .dsen_pls(dsen_pls), .status_pls(status_pls),
    .usb_ep(usb_ep), .usb_dir(usb_dir), .usb_setup(usb_setup),
    .usb_rx_done(usb_rx_done), .usb_rx_len(usb_rx_len), .usb_tx_done(usb_tx_done),
    .usb_ready(usb_ready), .usb_len(usb_len), .usb_stall(usb_stall)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bench model of the IN-buffer rules
  function automatic bit exp_tx_valid(int n, int mps, bit manual);
    return (n == mps) || manual;
  endfunction
  function automatic int exp_left(int len, int reads);
    return (reads >= len) ? 0 : len - reads;
  endfunction

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic sel(int ep, bit dir, bit setup);
    idx_ep = 2'(ep); idx_dir = dir; idx_setup = setup; idx_we = 1; tick(); idx_we = 0;
  endtask
  task automatic usel(int ep, bit dir, bit setup);
    usb_ep = 2'(ep); usb_dir = dir; usb_setup = setup; #1;
  endtask
  task automatic fnw(logic [7:0] d);
    fn_wdata = d; fn_we = 1; tick(); fn_we = 0;
  endtask
  task automatic setmps(int m);
    mps_wdata = CW'(m); mps_we = 1; tick(); mps_we = 0;
  endtask
  task automatic wr(int n);
    cpu_wr_stb = 1; repeat (n) tick(); cpu_wr_stb = 0;
  endtask
  task automatic rd(int n);
    cpu_rd_stb = 1; repeat (n) tick(); cpu_rd_stb = 0;
  endtask
  task automatic rx(int len);
    usb_rx_len = CW'(len); usb_rx_done = 1; tick(); usb_rx_done = 0;
  endtask
  task automatic tx(); usb_tx_done = 1; tick(); usb_tx_done = 0; endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1761));
    repeat (3) tick();
    rst_n = 1; tick();

    // R2 reset state
    sel(0, 0, 0); usel(0, 0, 0);
    check("R2 ctrl OUT cpu_ready", cpu_ready, 0);
    check("R2 cpu_cnt", cpu_cnt, 0);
    check("R2 fn_rdata", fn_rdata, 0);
    check("R2 ctrl OUT usb_ready", usb_ready, 1);
    sel(1, 1, 0);
    check("R2 IN cpu_ready", cpu_ready, 1);

    // R1 decode with SETUP priority, R3 drain
    usel(0, 0, 1); rx(8);
    check("R1 setup usb_ready after rx", usb_ready, 0);
    sel(0, 0, 0);
    check("R1 ctrl OUT empty", cpu_cnt, 0);
    sel(0, 1, 1);
    check("R1 setup wins over dir", cpu_cnt, 8);
    sel(2, 1, 1);
    check("R1 setup ignored on ep2", cpu_ready, 1);
    sel(0, 0, 1);
    rd(3);
    check("R3 count down", cpu_cnt, exp_left(8, 3));
    rd(5);
    check("R3 drained frees", cpu_ready, 0);
    check("R3 setup free for usb", usb_ready, 1);

    // R11, R4, R9 auto validate and ping-pong
    sel(1, 1, 0); setmps(4); usel(1, 1, 0);
    wr(3);
    check("R4 partial not valid", usb_ready, 0);
    check("R4 partial count", cpu_cnt, 3);
    wr(1);
    check("R4 full valid", usb_ready, exp_tx_valid(4, 4, 0));
    check("R11 len is mps", usb_len, 4);
    check("R9 second slot writable", cpu_ready, 1);
    check("R9 second slot count", cpu_cnt, 0);
    wr(4);
    check("R9 both full", cpu_ready, 0);
    tx();
    check("R5 next slot offered", usb_ready, 1);
    check("R5 cpu slot freed", cpu_ready, 1);
    tx();
    check("R5 all sent", usb_ready, 0);

    // R6 manual validate, zero length included
    wr(2); fnw(8'h08);
    check("R6 validate partial", usb_ready, 1);
    check("R6 validate len", usb_len, 2);
    tx(); fnw(8'h08);
    check("R6 zero length valid", usb_ready, 1);
    check("R6 zero length len", usb_len, 0);
    tx();

    // R8 clear, one per slot
    wr(8);
    fnw(8'h10);
    check("R8 first clear keeps one", usb_ready, 1);
    fnw(8'h10);
    check("R8 second clear empties", usb_ready, 0);
    check("R8 cpu slot free", cpu_ready, 1);
    wr(2); fnw(8'h10);
    check("R8 partial fill cleared", cpu_cnt, 0);

    // R7 stall
    wr(4); fnw(8'h01);
    check("R7 stall flag", usb_stall, 1);
    check("R7 stall hides ready", usb_ready, 0);
    check("R7 readback", fn_rdata, 1);
    tx(); fnw(8'h00);
    check("R7 tx ignored while stalled", usb_ready, 1);
    check("R7 len kept", usb_len, 4);
    tx();

    // R10 reserved bits and stage pulses
    wr(1); fnw(8'hE6);
    check("R10 dsen pulse", dsen_pls, 1);
    check("R10 status pulse", status_pls, 1);
    check("R10 readback zero", fn_rdata, 0);
    check("R10 count untouched", cpu_cnt, 1);
    check("R10 not validated", usb_ready, 0);
    tick();
    check("R10 dsen one cycle", dsen_pls, 0);
    fnw(8'h10);

    // R6 ignored on OUT, R9 on OUT, R3
    usel(2, 0, 0); rx(3);
    check("R9 OUT second slot free", usb_ready, 1);
    rx(5);
    check("R9 OUT both full", usb_ready, 0);
    sel(2, 0, 0);
    check("R3 OUT count", cpu_cnt, 3);
    fnw(8'h08);
    check("R6 no effect on OUT", cpu_cnt, 3);
    rd(3);
    check("R9 next OUT slot", cpu_cnt, 5);
    check("R3 slot freed for usb", usb_ready, 1);
    fnw(8'h10);
    check("R8 OUT clear", cpu_ready, 0);

    // R2 bus reset keeps mps
    sel(1, 1, 0); usel(1, 1, 0);
    wr(2); fnw(8'h01);
    bus_rst = 1; tick(); bus_rst = 0;
    check("R2 bus reset count", cpu_cnt, 0);
    check("R2 bus reset stall", usb_stall, 0);
    check("R2 bus reset readback", fn_rdata, 0);
    wr(4);
    check("R2 mps kept", usb_ready, 1);
    check("R2 mps kept len", usb_len, 4);
    tx();

    // random IN packets
    for (int i = 0; i < 30; i++) begin
      int ep, m, n;
      bit man;
      ep = 1 + int'($urandom % 3);
      m = 1 + int'($urandom % 12);
      n = int'($urandom % (m + 1));
      man = (n < m);
      sel(ep, 1, 0); usel(ep, 1, 0); setmps(m);
      wr(n);
      if (man) begin
        check("R4 random partial", usb_ready, 0);
        fnw(8'h08);
      end
      check("R4 random valid", usb_ready, exp_tx_valid(n, m, man));
      check("R4 random len", usb_len, n);
      tx();
      check("R5 random sent", usb_ready, 0);
    end

    // random OUT packets
    for (int i = 0; i < 30; i++) begin
      int ep, len, k;
      ep = 1 + int'($urandom % 3);
      len = 1 + int'($urandom % 20);
      k = int'($urandom % len);
      usel(ep, 0, 0); sel(ep, 0, 0);
      rx(len);
      check("R3 random load", cpu_cnt, len);
      rd(k);
      check("R3 random partial read", cpu_cnt, exp_left(len, k));
      rd(len - k);
      check("R3 random drained", cpu_ready, 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule